// File: doc/BRIEF.md
# Intra 4x4 Luma Sample Predictor

This block forms the sixteen predicted luma samples of one 4x4 block for an H.264 style decoder. A request carries a prediction mode from 0 to 8 and the reconstructed neighbours of the block. These are eight samples above (A..H), four samples to the left (I..L) and the above-left corner sample. Each group has its own availability flag. The neighbours must already hold reconstructed values, with the residual added, so the caller issues the next request only once the previous block has been rebuilt.

Eight of the nine modes run on one datapath. For each output column it picks four neighbour taps by mode and position, adds them, adds 2 and shifts right by two. Vertical and horizontal prediction use the same path with all four taps on one sample. Mean prediction takes a separate averaging path. It also supplies the fallback value when the selected mode needs a neighbour that is flagged unavailable. The rows leave the block one per cycle, after a single-cycle capture of the request.

Top module: `intra4_pred`

## Requirements
- R1: While reset is held and after it is released, `row_valid`, `done` and `mode_err` are low until a request is accepted.
- R2: `start` is accepted when the block is idle. At that edge the inputs are captured. Rows 0,1,2,3 then appear with `row_valid` high on the four consecutive cycles that begin two cycles after the accepting edge, with `row_idx` equal to the row number. `done` is high only together with row 3. `row_valid` is low on the following cycle. In `row_data`, column x is held in bits [x*W +: W].
- R3: A `start` that arrives while rows are being produced is ignored. Changed inputs at that time do not alter the rows of the block in flight, and no extra block follows.
- R4: Mode 0 copies the above sample of each column into every row. Mode 1 copies the left sample of each row into every column. `nb_above` holds A at bits [W-1:0] up to H, and `nb_left` holds I at bits [W-1:0] up to L.
- R5: Mode 2 with both above and left available gives every sample the value (A+B+C+D+I+J+K+L+4)>>3.
- R6: Mode 2 with only one side available gives (sum of that side's four samples + 2)>>2. With neither side available it gives 2^(W-1).
- R7: Every sample in modes 3 to 8 is (P0+P1+P2+P3+2)>>2 over four neighbour taps. In mode 3 (diagonal down-left) the top-left sample is (A+2B+C+2)>>2 and the bottom-right sample is (G+3H+2)>>2.
- R8: Modes 4 (diagonal down-right), 5 (vertical-right) and 6 (horizontal-down) follow the standard tap patterns through the corner sample. For example, the mode 5 top-right sample is (2C+2D+2)>>2.
- R9: Modes 7 (vertical-left) and 8 (horizontal-up) follow the standard tap patterns. In mode 8, every sample with x+2y greater than 5 equals L.
- R10: When `avail_above_right` is low, E..H are taken as copies of D for all modes.
- R11: If the mode needs a neighbour group that is flagged unavailable, or the mode code is above 8, `mode_err` is high with every row and all samples equal the mode-2 value. Modes 0, 3 and 7 need the above samples. Modes 1 and 8 need the left samples. Modes 4, 5 and 6 need above, left and corner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| mode | input | 4 | Prediction mode 0..8 |
| nb_above | input | 8*W | Above neighbours A..H, A in the low bits |
| nb_left | input | 4*W | Left neighbours I..L, I in the low bits |
| nb_corner | input | W | Above-left corner sample |
| avail_above | input | 1 | A..D are valid |
| avail_above_right | input | 1 | E..H are valid |
| avail_left | input | 1 | I..L are valid |
| avail_corner | input | 1 | Corner sample is valid |
| row_valid | output | 1 | A predicted row is on `row_data` |
| row_idx | output | 2 | Row number of the current row |
| row_data | output | 4*W | Four samples, column x in bits [x*W +: W] |
| mode_err | output | 1 | Selected mode lacked neighbours; fallback used |
| done | output | 1 | High with the last row of a block |

## Verification
The assertions assume that `start` is a clean level sampled at the clock and that the mode and neighbour inputs are stable at the accepting edge. The block captures its inputs only at that edge. The stimulus changes inputs and `start` only on the falling clock edge. It keeps `start` high during busy cycles only to exercise the ignore rule, and lowers it before the block goes idle again. The fallback-row property assumes that `mode_err` is meaningful only while `row_valid` is high, which the stimulus respects by sampling the two together.

// File: rtl/intra4_pkg.sv
package intra4_pkg;
  // neighbour line: L K J I M A B C D E F G H, index 0..12
  localparam int EDGE_N = 13;
  localparam int IDX_W  = 4;
  localparam int CORNER = 4;
  localparam int ABOVE0 = 5;
  localparam int LEFT0  = 3;

  typedef enum logic [3:0] {
    PM_VERT = 4'd0, PM_HORZ = 4'd1, PM_MEAN = 4'd2, PM_DDL = 4'd3,
    PM_DDR  = 4'd4, PM_VR   = 4'd5, PM_HD   = 4'd6, PM_VL  = 4'd7,
    PM_HU   = 4'd8
  } pmode_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} pstate_e;
endpackage

// File: rtl/intra4_dc.sv
module intra4_dc #(
  parameter int W = 8
) (
  input  logic [4*W-1:0] above_flat,
  input  logic [4*W-1:0] left_flat,
  input  logic           have_above,
  input  logic           have_left,
  output logic [W-1:0]   mean_val
);
  localparam int SW = W + 2;
  localparam int TW = W + 3;

  logic [SW-1:0] sum_up, sum_lf;
  logic [TW-1:0] both;
  logic [SW-1:0] one_up, one_lf;

  always_comb begin
    sum_up = '0;
    sum_lf = '0;
    for (int i = 0; i < 4; i++) begin
      sum_up = sum_up + SW'(above_flat[i*W +: W]);
      sum_lf = sum_lf + SW'(left_flat[i*W +: W]);
    end
    both   = TW'(sum_up) + TW'(sum_lf) + TW'(4);
    one_up = sum_up + SW'(2);
    one_lf = sum_lf + SW'(2);
    if (have_above && have_left) mean_val = both[TW-1:3];
    else if (have_above)          mean_val = one_up[SW-1:2];
    else if (have_left)           mean_val = one_lf[SW-1:2];
    else                          mean_val = W'(1) << (W - 1);
  end
endmodule

// File: rtl/intra4_tapsel.sv
module intra4_tapsel
  import intra4_pkg::*;
#(
  parameter int W   = 8,
  parameter int COL = 0
) (
  input  logic [3:0]          mode,
  input  logic [1:0]          row,
  input  logic [EDGE_N*W-1:0] edge_flat,
  output logic [W-1:0]        sample
);
  localparam int SW = W + 2;

  logic [IDX_W-1:0] t0, t1, t2, t3;
  logic [SW-1:0]    acc;

  always_comb begin
    int x, y, z, k;
    int a0, a1, a2, a3;
    x = COL;
    y = int'(row);
    z = 0;
    k = 0;
    a0 = CORNER; a1 = CORNER; a2 = CORNER; a3 = CORNER;
    case (mode)
      PM_VERT: begin a0 = ABOVE0 + x; a1 = a0; a2 = a0; a3 = a0; end
      PM_HORZ: begin a0 = LEFT0 - y;  a1 = a0; a2 = a0; a3 = a0; end
      PM_DDL: begin
        if (x == 3 && y == 3) begin a0 = 11; a1 = 12; a2 = 12; a3 = 12; end
        else begin
          k = x + y;
          a0 = 5 + k; a1 = 6 + k; a2 = 6 + k; a3 = 7 + k;
        end
      end
      PM_DDR: begin
        k = x - y;
        a0 = 3 + k; a1 = 4 + k; a2 = 4 + k; a3 = 5 + k;
      end
      PM_VR: begin
        z = 2 * x - y;
        k = x - (y >> 1);
        if (z >= 0 && z[0] == 1'b0) begin a0 = 4 + k; a1 = 4 + k; a2 = 5 + k; a3 = 5 + k; end
        else if (z >= -1)           begin a0 = 3 + k; a1 = 4 + k; a2 = 4 + k; a3 = 5 + k; end
        else                        begin a0 = 4 - y; a1 = 5 - y; a2 = 5 - y; a3 = 6 - y; end
      end
      PM_HD: begin
        z = 2 * y - x;
        k = y - (x >> 1);
        if (z >= 0 && z[0] == 1'b0) begin a0 = 3 - k; a1 = 3 - k; a2 = 4 - k; a3 = 4 - k; end
        else if (z >= -1)           begin a0 = 5 - k; a1 = 4 - k; a2 = 4 - k; a3 = 3 - k; end
        else                        begin a0 = 4 + x; a1 = 3 + x; a2 = 3 + x; a3 = 2 + x; end
      end
      PM_VL: begin
        k = x + (y >> 1);
        if (y[0] == 1'b0) begin a0 = 5 + k; a1 = 5 + k; a2 = 6 + k; a3 = 6 + k; end
        else              begin a0 = 5 + k; a1 = 6 + k; a2 = 6 + k; a3 = 7 + k; end
      end
      PM_HU: begin
        z = x + 2 * y;
        k = y + (x >> 1);
        if (z < 5 && z[0] == 1'b0) begin a0 = 3 - k; a1 = 3 - k; a2 = 2 - k; a3 = 2 - k; end
        else if (z < 5)            begin a0 = 3 - k; a1 = 2 - k; a2 = 2 - k; a3 = 1 - k; end
        else if (z == 5)           begin a0 = 1; a1 = 0; a2 = 0; a3 = 0; end
        else                       begin a0 = 0; a1 = 0; a2 = 0; a3 = 0; end
      end
      default: ;
    endcase
    t0 = IDX_W'(a0);
    t1 = IDX_W'(a1);
    t2 = IDX_W'(a2);
    t3 = IDX_W'(a3);
  end

  assign acc = SW'(edge_flat[t0*W +: W]) + SW'(edge_flat[t1*W +: W])
             + SW'(edge_flat[t2*W +: W]) + SW'(edge_flat[t3*W +: W]) + SW'(2);
  assign sample = acc[SW-1:2];
endmodule

// File: rtl/intra4_pred.sv
module intra4_pred
  import intra4_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [3:0]     mode,
  input  logic [8*W-1:0] nb_above,
  input  logic [4*W-1:0] nb_left,
  input  logic [W-1:0]   nb_corner,
  input  logic           avail_above,
  input  logic           avail_above_right,
  input  logic           avail_left,
  input  logic           avail_corner,
  output logic           row_valid,
  output logic [1:0]     row_idx,
  output logic [4*W-1:0] row_data,
  output logic           mode_err,
  output logic           done
);
  localparam int ROWS = 4;

  pstate_e             state;
  logic [1:0]          cnt;
  logic [3:0]          mode_q;
  logic                err_q, up_q, lf_q;
  logic [W-1:0]        edge_q [EDGE_N];
  logic [EDGE_N*W-1:0] edge_flat;
  logic [W-1:0]        mean_val;
  logic [W-1:0]        col_s [ROWS];
  logic [4*W-1:0]      row_next;
  logic                accept, need_up, need_lf, need_cr, bad_code;

  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    bad_code = (mode > 4'd8);
    need_up  = (mode == PM_VERT) || (mode == PM_DDL) || (mode == PM_VL) ||
               (mode == PM_DDR) || (mode == PM_VR) || (mode == PM_HD);
    need_lf  = (mode == PM_HORZ) || (mode == PM_HU) ||
               (mode == PM_DDR) || (mode == PM_VR) || (mode == PM_HD);
    need_cr  = (mode == PM_DDR) || (mode == PM_VR) || (mode == PM_HD);
  end

  generate
    for (genvar i = 0; i < EDGE_N; i++) begin : g_flat
      assign edge_flat[i*W +: W] = edge_q[i];
    end
  endgenerate

  intra4_dc #(.W(W)) u_dc (
    .above_flat ({edge_q[8], edge_q[7], edge_q[6], edge_q[5]}),
    .left_flat  ({edge_q[0], edge_q[1], edge_q[2], edge_q[3]}),
    .have_above (up_q),
    .have_left  (lf_q),
    .mean_val   (mean_val)
  );

  generate
    for (genvar c = 0; c < ROWS; c++) begin : g_col
      intra4_tapsel #(.W(W), .COL(c)) u_tap (
        .mode      (mode_q),
        .row       (cnt),
        .edge_flat (edge_flat),
        .sample    (col_s[c])
      );
      assign row_next[c*W +: W] = (err_q || mode_q == PM_MEAN) ? mean_val : col_s[c];
    end
  endgenerate

  // neighbour capture: no reset needed on data registers
  always_ff @(posedge clk) begin
    if (accept) begin
      mode_q <= mode;
      up_q   <= avail_above;
      lf_q   <= avail_left;
      err_q  <= bad_code || (need_up && !avail_above) || (need_lf && !avail_left) ||
                (need_cr && !avail_corner);
      edge_q[CORNER] <= nb_corner;
      for (int i = 0; i < 4; i++) begin
        edge_q[LEFT0 - i]  <= nb_left[i*W +: W];
        edge_q[ABOVE0 + i] <= nb_above[i*W +: W];
        edge_q[ABOVE0 + 4 + i] <= avail_above_right ? nb_above[(i+4)*W +: W]
                                                    : nb_above[3*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      row_valid <= 1'b0;
      row_idx   <= '0;
      row_data  <= '0;
      mode_err  <= 1'b0;
      done      <= 1'b0;
    end else begin
      row_valid <= 1'b0;
      done      <= 1'b0;
      mode_err  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          row_valid <= 1'b1;
          row_idx   <= cnt;
          row_data  <= row_next;
          mode_err  <= err_q;
          done      <= (cnt == 2'd3);
          cnt       <= cnt + 2'd1;
          if (cnt == 2'd3) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_row0_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##2 (row_valid && row_idx == 2'd0));

  // R2
  row_order_chk: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_idx != 2'd3) |=> (row_valid && row_idx == $past(row_idx) + 2'd1));

  // R2
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (row_valid && row_idx == 2'd3));

  // R3
  no_tail_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !row_valid);

  // R11
  fallback_flat_chk: assert property (@(posedge clk) disable iff (rst)
    (row_valid && mode_err) |-> (row_data[0 +: W] == row_data[W +: W] &&
                                 row_data[W +: W] == row_data[2*W +: W] &&
                                 row_data[2*W +: W] == row_data[3*W +: W]));

  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!row_valid) |-> (!done && !mode_err));
endmodule

// File: tb/intra4_pred_test.sv
module intra4_pred_test;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [3:0]     mode = '0;
  logic [8*W-1:0] nb_above = '0;
  logic [4*W-1:0] nb_left = '0;
  logic [W-1:0]   nb_corner = '0;
  logic           avail_above = 1'b1, avail_above_right = 1'b1;
  logic           avail_left = 1'b1, avail_corner = 1'b1;
  logic           row_valid, mode_err, done;
  logic [1:0]     row_idx;
  logic [4*W-1:0] row_data;

  int total = 0;
  int bad = 0;
  int ab [8];
  int lf [4];
  int cm;
  bit finished = 0;

  always #10 clk = ~clk;

  intra4_pred #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .nb_above(nb_above), .nb_left(nb_left), .nb_corner(nb_corner),
    .avail_above(avail_above), .avail_above_right(avail_above_right),
    .avail_left(avail_left), .avail_corner(avail_corner),
    .row_valid(row_valid), .row_idx(row_idx), .row_data(row_data),
    .mode_err(mode_err), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int px(int x, int y);
    if (y < 0) return (x < 0) ? cm : ab[x];
    return lf[y];
  endfunction
  function automatic int f3(int a, int b, int c);
    return (a + 2*b + c + 2) >> 2;
  endfunction
  function automatic int f2(int a, int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic int mean_ref(bit u, bit l);
    int su, sl;
    su = ab[0] + ab[1] + ab[2] + ab[3];
    sl = lf[0] + lf[1] + lf[2] + lf[3];
    if (u && l) return (su + sl + 4) >> 3;
    if (u) return (su + 2) >> 2;
    if (l) return (sl + 2) >> 2;
    return 1 << (W - 1);
  endfunction

  function automatic int pred_ref(int md, int x, int y);
    int z;
    case (md)
      0: return px(x, -1);
      1: return px(-1, y);
      3: return (x == 3 && y == 3) ? f3(px(6,-1), px(7,-1), px(7,-1))
                                   : f3(px(x+y,-1), px(x+y+1,-1), px(x+y+2,-1));
      4: if (x > y) return f3(px(x-y-2,-1), px(x-y-1,-1), px(x-y,-1));
         else if (x < y) return f3(px(-1,y-x-2), px(-1,y-x-1), px(-1,y-x));
         else return f3(px(0,-1), px(-1,-1), px(-1,0));
      5: begin
        z = 2*x - y;
        if (z >= 0 && z % 2 == 0) return f2(px(x-(y>>1)-1,-1), px(x-(y>>1),-1));
        if (z > 0) return f3(px(x-(y>>1)-2,-1), px(x-(y>>1)-1,-1), px(x-(y>>1),-1));
        if (z == -1) return f3(px(-1,0), px(-1,-1), px(0,-1));
        return f3(px(-1,y-1), px(-1,y-2), px(-1,y-3));
      end
      6: begin
        z = 2*y - x;
        if (z >= 0 && z % 2 == 0) return f2(px(-1,y-(x>>1)-1), px(-1,y-(x>>1)));
        if (z > 0) return f3(px(-1,y-(x>>1)-2), px(-1,y-(x>>1)-1), px(-1,y-(x>>1)));
        if (z == -1) return f3(px(-1,0), px(-1,-1), px(0,-1));
        return f3(px(x-1,-1), px(x-2,-1), px(x-3,-1));
      end
      7: if (y % 2 == 0) return f2(px(x+(y>>1),-1), px(x+(y>>1)+1,-1));
         else return f3(px(x+(y>>1),-1), px(x+(y>>1)+1,-1), px(x+(y>>1)+2,-1));
      8: begin
        z = x + 2*y;
        if (z < 5 && z % 2 == 0) return f2(px(-1,y+(x>>1)), px(-1,y+(x>>1)+1));
        if (z < 5) return f3(px(-1,y+(x>>1)), px(-1,y+(x>>1)+1), px(-1,y+(x>>1)+2));
        if (z == 5) return (px(-1,2) + 3*px(-1,3) + 2) >> 2;
        return px(-1,3);
      end
      default: return 0;
    endcase
  endfunction

  function automatic bit err_ref(int md, bit u, bit l, bit c);
    if (md > 8) return 1;
    if ((md == 0 || md == 3 || md == 7) && !u) return 1;
    if ((md == 1 || md == 8) && !l) return 1;
    if ((md >= 4 && md <= 6) && !(u && l && c)) return 1;
    return 0;
  endfunction

  task automatic load(input int seed);
    for (int i = 0; i < 8; i++) begin
      ab[i] = (seed * 37 + i * 71 + 13) % 256;
      nb_above[i*W +: W] = W'(ab[i]);
    end
    for (int i = 0; i < 4; i++) begin
      lf[i] = (seed * 53 + i * 97 + 7) % 256;
      nb_left[i*W +: W] = W'(lf[i]);
    end
    cm = (seed * 29 + 101) % 256;
    nb_corner = W'(cm);
  endtask

  task automatic run_block(input int md, input bit u, input bit ur, input bit l,
                           input bit c, input string req, input bit poke);
    int exp_row, got_row;
    bit e;
    @(negedge clk);
    mode = 4'(md);
    avail_above = u; avail_above_right = ur; avail_left = l; avail_corner = c;
    start = 1'b1;
    if (!ur) for (int i = 4; i < 8; i++) ab[i] = ab[3];
    e = err_ref(md, u, l, c);
    @(negedge clk);
    chk(!row_valid, "R2", "row_valid one cycle after accept", row_valid, 0);
    if (poke) begin
      mode = 4'((md + 1) % 9);
      nb_above = ~nb_above;
      nb_left = ~nb_left;
      nb_corner = ~nb_corner;
    end else start = 1'b0;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      if (r == 2) start = 1'b0;
      chk(row_valid && row_idx == 2'(r) && done == (r == 3), "R2",
          $sformatf("row %0d timing valid/idx/done", r),
          {row_valid, row_idx, done}, {1'b1, 2'(r), (r == 3)});
      chk(mode_err == e, "R11", $sformatf("mode_err row %0d mode %0d", r, md),
          mode_err, e);
      for (int x = 0; x < 4; x++) begin
        if (e || md == 2) exp_row = mean_ref(u, l);
        else exp_row = pred_ref(md, x, r);
        got_row = int'(row_data[x*W +: W]);
        chk(got_row == exp_row, req, $sformatf("mode %0d x=%0d y=%0d", md, x, r),
            got_row, exp_row);
      end
    end
    @(negedge clk);
    chk(!row_valid && !done, poke ? "R3" : "R2", "idle after block",
        {row_valid, done}, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!row_valid && !done && !mode_err, "R1", "outputs in reset",
        {row_valid, done, mode_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!row_valid && !done && !mode_err, "R1", "outputs after reset",
        {row_valid, done, mode_err}, 0);
  endtask

  task automatic test_copy();
    load(1); run_block(0, 1, 1, 1, 1, "R4", 0);
    load(2); run_block(1, 1, 1, 1, 1, "R4", 0);
  endtask

  task automatic test_mean();
    load(3); run_block(2, 1, 1, 1, 1, "R5", 0);
    load(4); run_block(2, 1, 1, 0, 1, "R6", 0);
    load(5); run_block(2, 0, 0, 1, 0, "R6", 0);
    load(6); run_block(2, 0, 0, 0, 0, "R6", 0);
  endtask

  task automatic test_diag();
    load(7); run_block(3, 1, 1, 1, 1, "R7", 0);
    load(8);
    for (int i = 0; i < 8; i++) begin ab[i] = 255; nb_above[i*W +: W] = 8'hFF; end
    run_block(3, 1, 1, 1, 1, "R7", 0);
    load(9); run_block(4, 1, 1, 1, 1, "R8", 0);
    load(10); run_block(5, 1, 1, 1, 1, "R8", 0);
    load(11); run_block(6, 1, 1, 1, 1, "R8", 0);
    load(12); run_block(7, 1, 1, 1, 1, "R9", 0);
    load(13); run_block(8, 1, 1, 1, 1, "R9", 0);
  endtask

  task automatic test_right_fill();
    load(14); run_block(3, 1, 0, 1, 1, "R10", 0);
    load(15); run_block(7, 1, 0, 0, 0, "R10", 0);
  endtask

  task automatic test_errors();
    load(16); run_block(0, 0, 1, 1, 1, "R11", 0);
    load(17); run_block(4, 1, 1, 1, 0, "R11", 0);
    load(18); run_block(8, 1, 1, 0, 1, "R11", 0);
    load(19); run_block(12, 1, 1, 1, 1, "R11", 0);
  endtask

  task automatic test_busy();
    load(20); run_block(5, 1, 1, 1, 1, "R3", 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    test_reset();
    test_copy();
    test_mean();
    test_diag();
    test_right_fill();
    test_errors();
    test_busy();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule